// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Trigger

This block buffers received serial characters between a receive shift register and a read port. Characters arrive through a valid/ready push port. Each accepted character is first captured in a one-entry holding slot. From there it moves into a 64-entry first-in first-out store, which is written so that block RAM can be inferred. A read strobe removes the oldest stored character, and the data appears on the output one clock later. A read issued while the store is empty produces zero.

When the store is full, the holding slot keeps its character and drops the ready signal, which stalls the receiver. On the edge where a read frees an entry, the held character moves into the store, so the level stays at the maximum. The block also reports empty, full and the current fill level. A sticky trigger flag sets when the fill level climbs to a programmed threshold. A clear strobe resets the flag, and a threshold of zero disables it.

Top module: `rx_fifo_trig`

## Requirements
- R1: After a synchronous reset: `empty`=1, `full`=0, `level`=0, `trig`=0, `in_ready`=1 and `rd_data`=0. Any stored or held character is discarded.
- R2: Characters are read out in the order in which they were accepted. The data for a read strobe given in cycle N is valid on `rd_data` after the rising edge that ends cycle N, and it stays there until the next read.
- R3: A character accepted on edge N enters the store on edge N+1. `empty` falls after that second edge and stays low until every stored character has been read.
- R4: A read strobe while `empty`=1 drives `rd_data` to 0 after the edge and leaves `level` unchanged.
- R5: `full` is 1 exactly when `level` equals 64. `level` never exceeds 64.
- R6: `in_ready` is 0 exactly while the holding slot is occupied and the store is full. No character is accepted then, and the held character is kept unchanged.
- R7: A read from a full store with an occupied holding slot moves the held character into the store on the same edge. `level` stays 64, and the held character is read out after all older ones.
- R8: A read and a store write on the same edge, with the store not empty, leave `level` unchanged. Both operations take effect.
- R9: With `thresh` in 1..63, `trig` sets on the edge where `level` rises from `thresh`-1 to `thresh`. It then stays set.
- R10: `trig` does not set when `level` falls through `thresh`, and it does not set when `thresh` is 0.
- R11: `trig_clr` clears `trig` on the next edge. If a set and a clear fall on the same edge, the set wins.
- R12: `level` reports the number of characters in the store. A character waiting in the holding slot is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receiver offers a character |
| in_data | input | 8 | Offered character |
| in_ready | output | 1 | Character accepted when high together with in_valid |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Character read, or zero for a read while empty |
| thresh | input | 6 | Trigger threshold, 0 disables |
| trig_clr | input | 1 | Clears the trigger flag |
| trig | output | 1 | Sticky threshold-crossing flag |
| empty | output | 1 | Store holds no character |
| full | output | 1 | Store holds 64 characters |
| level | output | 7 | Current fill level of the store |

## Verification
The hardest state to reach from the ports is a full store with a second character stalled in the holding slot, followed by a read that frees one entry. Reaching it takes 65 accepted characters with no reads. A further push is then attempted to confirm it is refused, and a single read shows the held character moving in while `level` stays at 64. A trigger set that coincides with a clear is another hard case, because the crossing edge comes one cycle after the push that causes it. The stimulus fills the store to one below the threshold and then asserts the clear in the cycle where the held character drains.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic {
    HOLD_FREE = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_st_e;
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM template
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          store_full,
  input  logic          store_pop,
  output logic          drain,
  output logic [DW-1:0] drain_data
);
  hold_st_e      st_q;
  logic [DW-1:0] data_q;
  logic          accept;

  // the slot may refill in the same cycle it empties into the store
  assign in_ready   = (st_q == HOLD_FREE) || !store_full;
  assign accept     = in_valid && in_ready;
  assign drain      = (st_q == HOLD_BUSY) && (!store_full || store_pop);
  assign drain_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= HOLD_FREE;
      data_q <= '0;
    end else begin
      if (accept) begin
        st_q   <= HOLD_BUSY;
        data_q <= in_data;
      end else if (drain) begin
        st_q <= HOLD_FREE;
      end
    end
  end

  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == HOLD_BUSY && store_full && !store_pop) |=> (st_q == HOLD_BUSY && $stable(data_q)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == HOLD_BUSY && store_full) |-> !in_ready);
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int CW = 7,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level_q,
  input  logic [CW-1:0] level_d,
  input  logic [TW-1:0] thresh,
  input  logic          clr,
  output logic          trig
);
  logic [CW-1:0] th_ext;
  logic          hit;

  assign th_ext = CW'(thresh);
  // the level moves by at most one per edge, so an upward crossing is
  // exactly a step from thresh-1 to thresh
  assign hit = (thresh != '0) && (level_q == th_ext - CW'(1)) && (level_d == th_ext);

  always_ff @(posedge clk) begin
    if (rst)      trig <= 1'b0;
    else if (hit) trig <= 1'b1;
    else if (clr) trig <= 1'b0;
  end

  assert_trig_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (trig && !clr) |=> trig);

  assert_trig_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (thresh == '0 && !trig) |=> !trig);

  assert_trig_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !trig);
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] thresh,
  input  logic          trig_clr,
  output logic          trig,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          empty_q, full_q;
  logic          pop, drain;
  logic [DW-1:0] drain_data, ram_q;
  logic          zero_q;

  assign pop = rd_en && !empty_q;

  rxq_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .store_full (full_q),
    .store_pop  (pop),
    .drain      (drain),
    .drain_data (drain_data)
  );

  rxq_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (drain),
    .waddr (wptr_q),
    .wdata (drain_data),
    .re    (pop),
    .raddr (rptr_q),
    .rdata (ram_q)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (drain && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !drain) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      zero_q  <= 1'b1;
    end else begin
      if (drain) wptr_q <= wptr_q + AW'(1);
      if (pop)   rptr_q <= rptr_q + AW'(1);
      cnt_q   <= cnt_d;
      empty_q <= (cnt_d == '0);
      full_q  <= (cnt_d == CW'(DEPTH));
      if (rd_en) zero_q <= empty_q;
    end
  end

  rxq_trig #(.CW(CW), .TW(AW)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .level_q (cnt_q),
    .level_d (cnt_d),
    .thresh  (thresh),
    .clr     (trig_clr),
    .trig    (trig)
  );

  assign rd_data = zero_q ? '0 : ram_q;
  assign empty   = empty_q;
  assign full    = full_q;
  assign level   = cnt_q;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  assert_full_flag_R5: assert property (@(posedge clk) disable iff (rst)
    full == (level == CW'(DEPTH)));

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (rd_data == '0 && $stable(level)));

  assert_level_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (drain && pop) |=> $stable(level));

  assert_full_refill_R7: assert property (@(posedge clk) disable iff (rst)
    (full && !in_ready && rd_en) |=> full);
endmodule

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] thresh = '0;
  logic       trig_clr = 1'b0;
  logic       trig, empty, full;
  logic [6:0] level;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model of the requirements
  logic [7:0] stor[$];
  int   mcnt  = 0;
  bit   mhold = 1'b0;
  bit   mtrig = 1'b0;

  // scoreboard for read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         mon_chk = 1'b0;

  always #2.5 clk = ~clk;

  rx_fifo_trig u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data), .thresh(thresh),
    .trig_clr(trig_clr), .trig(trig), .empty(empty), .full(full), .level(level)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: a read strobe seen at an edge is compared at the next falling edge
  always @(posedge clk) mon_chk <= rd_en && !rst;

  always @(negedge clk) begin
    if (mon_chk) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data == e, t, rd_data, e);
    end
  end

  // one cycle of stimulus, started and finished at a falling edge
  task automatic step(input bit v, input logic [7:0] d, input bit r, input bit c);
    bit acc, pop, drn;
    int ncnt;
    in_valid = v; in_data = d; rd_en = r; trig_clr = c;
    acc = v && (!mhold || mcnt < 64);
    chk(in_ready == (!mhold || mcnt < 64), "R6 in_ready", in_ready, int'(!mhold || mcnt < 64));
    pop = r && mcnt > 0;
    drn = mhold && (mcnt < 64 || pop);
    if (r) begin
      if (pop) begin exp_q.push_back(stor.pop_front()); tag_q.push_back("R2 data order"); end
      else     begin exp_q.push_back(8'h00);            tag_q.push_back("R4 empty read"); end
    end
    if (acc) stor.push_back(d);
    ncnt = mcnt + int'(drn) - int'(pop);
    if (thresh != 0 && mcnt == int'(thresh) - 1 && ncnt == int'(thresh)) mtrig = 1'b1;
    else if (c) mtrig = 1'b0;
    mhold = acc ? 1'b1 : (drn ? 1'b0 : mhold);
    mcnt  = ncnt;
    @(negedge clk);
    in_valid = 1'b0; rd_en = 1'b0; trig_clr = 1'b0;
    chk(level == mcnt, "R12 level", level, mcnt);
    chk(empty == (mcnt == 0), "R3 empty", empty, int'(mcnt == 0));
    chk(full == (mcnt == 64), "R5 full", full, int'(mcnt == 64));
    chk(trig == mtrig, "R9 trig", trig, mtrig);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    stor.delete(); mcnt = 0; mhold = 1'b0; mtrig = 1'b0;
    @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0 && level == 0, "R1 flags", {empty, full}, 2);
    chk(trig == 1'b0 && in_ready == 1'b1, "R1 trig/ready", {trig, in_ready}, 1);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R4: reading an empty queue returns zero
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);

    // R3, R9: push five with threshold 3
    thresh = 6'd3;
    step(1, 8'hA1, 0, 0);
    chk(empty == 1'b1, "R3 empty after one edge", empty, 1);
    for (int i = 0; i < 4; i++) step(1, 8'hB0 + 8'(i), 0, 0);
    step(0, 0, 0, 0);
    chk(trig == 1'b1, "R9 trig set at level 3", trig, 1);

    // R8: simultaneous push and pop
    step(1, 8'hC1, 1, 0);
    step(1, 8'hC2, 1, 0);
    step(0, 0, 1, 0);

    // R11: clear, then drain downward through the threshold (R10)
    step(0, 0, 0, 1);
    chk(trig == 1'b0, "R11 trig cleared", trig, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0);
    chk(trig == 1'b0, "R10 no trig on falling level", trig, 0);

    // R10 disabled threshold; R5, R6, R7 full with a held character
    thresh = 6'd0;
    for (int i = 0; i < 65; i++) step(1, 8'(i * 3 + 1), 0, 0);
    step(0, 0, 0, 0);
    chk(full == 1'b1 && level == 64, "R5 full at 64", level, 64);
    chk(trig == 1'b0, "R10 disabled threshold", trig, 0);
    step(1, 8'hEE, 0, 0);
    chk(in_ready == 1'b0, "R6 stalled", in_ready, 0);
    step(0, 0, 1, 0);
    chk(level == 64, "R7 refill keeps level", level, 64);
    for (int i = 0; i < 66; i++) step(0, 0, 1, 0);

    // R9 at threshold 63, R11 set wins over a coinciding clear
    thresh = 6'd63;
    for (int i = 0; i < 62; i++) step(1, 8'(i), 0, 0);
    step(0, 0, 0, 0);
    step(1, 8'h77, 0, 0);
    step(0, 0, 0, 1);
    chk(trig == 1'b1, "R11 set wins over clear", trig, 1);
    step(0, 0, 0, 1);
    chk(trig == 1'b0, "R11 clear later", trig, 0);

    // R1: reset in mid operation discards contents
    step(1, 8'h55, 0, 0);
    do_reset();
    step(0, 0, 1, 0);

    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule